// File: doc/BRIEF.md
# Link Width Configuration Register

This block is the width-control register for one side of a point-to-point serial link. Software reads and writes a single 32-bit word. The word carries a programmable outgoing width, a programmable incoming width, two read-only maximum-width fields and two single-bit flags. The flags are a 64-bit address enable and an extended control-hold select.

A width write only updates a pending copy. The active widths that drive the link datapath take the pending value at one of two moments: the edge where a link reset is sampled, or the edge where a link-stop disconnect-complete strobe is sampled.

The register spans two reset domains. The asynchronous power-good reset clears everything. The synchronous link reset leaves the programmed fields and flags untouched. The block also contains the initialization timer. After link-stop is released and control-in is then seen high, the timer holds the control-out line asserted. The hold lasts either 16 bit times or a long interval set by a cycle-count parameter (about 50 microseconds).

Top module: `link_width_csr`

## Requirements
- R1: After power-good reset, pending and active widths both equal `DEF_WIDTH` (default 000b, 8 bits), both flags are 0, `ctlOutHold` is 0, and a read returns 32'h0011_0000.
- R2: Writing a legal code updates the pending outgoing width at read bits 30:28 or the pending incoming width at read bits 24 to 26. Legal codes are 000b = 8 bits, 001b = 16 bits, 100b = 2 bits, 101b = 4 bits and 111b = not connected.
- R3: A write carrying an illegal code (010b, 011b, 110b) in a width field leaves that field's pending value unchanged. A legal code in the other field of the same write is still accepted.
- R4: Read bits 22:20 and 18:16 always return 001b. Bits 31, 27, 23, 19 and 13:0 always read 0, and writes to them have no effect.
- R5: Bit 15 (64-bit address enable) and bit 14 (extended control hold) are read-write. Output `addr64En` follows bit 15 from the cycle after the write.
- R6: The active widths change only at a clock edge where `linkRst` or `discDone` is sampled high. At that edge they load the pending widths. At all other edges they stay stable.
- R7: When a write and an apply strobe are sampled at the same edge, the active widths take the pending value from before the write. The written value stays pending until the next apply.
- R8: A link reset keeps the pending widths and both flags. A power-good reset returns them to their defaults.
- R9: `ctlOutHold` rises one cycle after `ctlIn` is sampled high while the timer waits after a link-stop release (`linkStopN` low, then high). `ctlIn` has no effect at any other time.
- R10: With bit 14 = 0 at hold start, `ctlOutHold` stays high until the edge that samples the 16th `bitClkTick` pulse, then falls.
- R11: With bit 14 = 1 at hold start, `ctlOutHold` stays high for exactly `HOLD_LONG_CYCLES` clock cycles.
- R12: A link-stop assertion or a link reset during a hold drops `ctlOutHold` on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register and timer clock |
| pwrGoodRstN | input | 1 | Asynchronous power-good reset, active low |
| linkRst | input | 1 | Synchronous link reset, active high; applies pending widths |
| discDone | input | 1 | Link-stop disconnect complete strobe; applies pending widths |
| regWrEn | input | 1 | Register write enable |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data |
| linkStopN | input | 1 | Link-stop request, active low |
| ctlIn | input | 1 | Incoming control line |
| bitClkTick | input | 1 | One pulse per link bit time |
| ctlOutHold | output | 1 | Hold control-out asserted during initialization |
| activeWidthOut | output | 3 | Active outgoing width code |
| activeWidthIn | output | 3 | Active incoming width code |
| addr64En | output | 1 | 64-bit address enable flag |

## Verification
A register write and a width apply can land on the same edge. The bench raises `regWrEn` with a new width in the same cycle that `discDone`, or separately `linkRst`, is high. It then judges the result at two points. Right after that edge, the active width must show the old pending value while the read port shows the new one. After a later lone apply strobe, the active width must show the new value. A write that changes bit 14 while a hold is already running is also checked: it must not change the length of that hold.

// File: rtl/lwc_pkg.sv
package lwc_pkg;

  localparam int OUT_LSB  = 28;
  localparam int IN_LSB   = 24;
  localparam int MAXO_LSB = 20;
  localparam int MAXI_LSB = 16;
  localparam int A64_BIT  = 15;
  localparam int EXT_BIT  = 14;

  localparam logic [2:0] WC_8  = 3'b000;
  localparam logic [2:0] WC_16 = 3'b001;
  localparam logic [2:0] WC_2  = 3'b100;
  localparam logic [2:0] WC_4  = 3'b101;
  localparam logic [2:0] WC_NC = 3'b111;
  localparam logic [2:0] WC_MAX = WC_16;

  typedef struct packed {
    logic loadOut;
    logic loadIn;
    logic loadFlags;
    logic apply;
  } csrStrobe_t;

  typedef enum logic [1:0] {
    T_IDLE    = 2'd0,
    T_STOPPED = 2'd1,
    T_WAIT    = 2'd2,
    T_HOLD    = 2'd3
  } initState_t;

  function automatic logic isLegalWidth(input logic [2:0] code);
    case (code)
      WC_8, WC_16, WC_2, WC_4, WC_NC: isLegalWidth = 1'b1;
      default:                        isLegalWidth = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/lwc_ctrl.sv
module lwc_ctrl
  import lwc_pkg::*;
#(
  parameter int HOLD_LONG_CYCLES = 6250,
  parameter int SHORT_HOLD_TICKS = 16
) (
  input  logic        clk,
  input  logic        pwrGoodRstN,
  input  logic        linkRst,
  input  logic        discDone,
  input  logic        regWrEn,
  input  logic [31:0] regWrData,
  input  logic        extCtl,
  input  logic        linkStopN,
  input  logic        ctlIn,
  input  logic        bitClkTick,
  output csrStrobe_t  strb,
  output logic        ctlOutHold
);

  localparam int CNT_MAX = (HOLD_LONG_CYCLES > SHORT_HOLD_TICKS) ? HOLD_LONG_CYCLES : SHORT_HOLD_TICKS;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(HOLD_LONG_CYCLES - 1);
  localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(SHORT_HOLD_TICKS - 1);

  // write qualification: each width field is screened on its own
  always_comb begin
    strb.loadOut   = regWrEn && isLegalWidth(regWrData[OUT_LSB +: 3]);
    strb.loadIn    = regWrEn && isLegalWidth(regWrData[IN_LSB +: 3]);
    strb.loadFlags = regWrEn;
    strb.apply     = linkRst || discDone;
  end

  initState_t       initState;
  logic [CNT_W-1:0] holdCnt;
  logic             holdLong;

  always_ff @(posedge clk or negedge pwrGoodRstN) begin
    if (!pwrGoodRstN) begin
      initState <= T_IDLE;
      holdCnt   <= '0;
      holdLong  <= 1'b0;
    end else if (linkRst) begin
      initState <= T_IDLE;
      holdCnt   <= '0;
    end else if (!linkStopN) begin
      initState <= T_STOPPED;
      holdCnt   <= '0;
    end else begin
      case (initState)
        T_STOPPED: initState <= T_WAIT;
        T_WAIT: begin
          if (ctlIn) begin
            initState <= T_HOLD;
            holdCnt   <= '0;
            holdLong  <= extCtl;
          end
        end
        T_HOLD: begin
          if (holdLong) begin
            if (holdCnt == LONG_LAST) initState <= T_IDLE;
            else                      holdCnt   <= holdCnt + 1'b1;
          end else if (bitClkTick) begin
            if (holdCnt == SHORT_LAST) initState <= T_IDLE;
            else                       holdCnt   <= holdCnt + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign ctlOutHold = (initState == T_HOLD);

  // R9
  hold_after_ctlin_chk: assert property (@(posedge clk) disable iff (!pwrGoodRstN)
    $rose(ctlOutHold) |-> $past(ctlIn));

  // R10
  short_end_on_tick_chk: assert property (@(posedge clk) disable iff (!pwrGoodRstN)
    ($fell(ctlOutHold) && !$past(holdLong) && !$past(linkRst) && $past(linkStopN))
      |-> $past(bitClkTick));

  // R12
  stop_drops_hold_chk: assert property (@(posedge clk) disable iff (!pwrGoodRstN)
    (!linkStopN || linkRst) |=> !ctlOutHold);

endmodule

// File: rtl/lwc_datapath.sv
module lwc_datapath
  import lwc_pkg::*;
#(
  parameter logic [2:0] DEF_WIDTH = 3'b000
) (
  input  logic        clk,
  input  logic        pwrGoodRstN,
  input  csrStrobe_t  strb,
  input  logic [31:0] wrData,
  output logic [2:0]  activeOut,
  output logic [2:0]  activeIn,
  output logic        addr64En,
  output logic        extCtl,
  output logic [31:0] rdData
);

  logic [2:0] pendOut, pendIn;

  always_ff @(posedge clk or negedge pwrGoodRstN) begin
    if (!pwrGoodRstN) begin
      pendOut   <= DEF_WIDTH;
      pendIn    <= DEF_WIDTH;
      activeOut <= DEF_WIDTH;
      activeIn  <= DEF_WIDTH;
      addr64En  <= 1'b0;
      extCtl    <= 1'b0;
    end else begin
      if (strb.apply) begin
        activeOut <= pendOut;
        activeIn  <= pendIn;
      end
      if (strb.loadOut) pendOut <= wrData[OUT_LSB +: 3];
      if (strb.loadIn)  pendIn  <= wrData[IN_LSB +: 3];
      if (strb.loadFlags) begin
        addr64En <= wrData[A64_BIT];
        extCtl   <= wrData[EXT_BIT];
      end
    end
  end

  always_comb begin
    rdData                 = '0;
    rdData[OUT_LSB +: 3]   = pendOut;
    rdData[IN_LSB +: 3]    = pendIn;
    rdData[MAXO_LSB +: 3]  = WC_MAX;
    rdData[MAXI_LSB +: 3]  = WC_MAX;
    rdData[A64_BIT]        = addr64En;
    rdData[EXT_BIT]        = extCtl;
  end

  // R3
  pend_legal_chk: assert property (@(posedge clk) disable iff (!pwrGoodRstN)
    isLegalWidth(pendOut) && isLegalWidth(pendIn));

endmodule

// File: rtl/link_width_csr.sv
module link_width_csr
  import lwc_pkg::*;
#(
  parameter logic [2:0] DEF_WIDTH        = 3'b000,
  parameter int         HOLD_LONG_CYCLES = 6250,
  parameter int         SHORT_HOLD_TICKS = 16
) (
  input  logic        clk,
  input  logic        pwrGoodRstN,
  input  logic        linkRst,
  input  logic        discDone,
  input  logic        regWrEn,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  input  logic        linkStopN,
  input  logic        ctlIn,
  input  logic        bitClkTick,
  output logic        ctlOutHold,
  output logic [2:0]  activeWidthOut,
  output logic [2:0]  activeWidthIn,
  output logic        addr64En
);

  csrStrobe_t strb;
  logic       extCtl;

  lwc_ctrl #(
    .HOLD_LONG_CYCLES(HOLD_LONG_CYCLES),
    .SHORT_HOLD_TICKS(SHORT_HOLD_TICKS)
  ) i_ctrl (
    .clk(clk), .pwrGoodRstN(pwrGoodRstN), .linkRst(linkRst), .discDone(discDone),
    .regWrEn(regWrEn), .regWrData(regWrData), .extCtl(extCtl),
    .linkStopN(linkStopN), .ctlIn(ctlIn), .bitClkTick(bitClkTick),
    .strb(strb), .ctlOutHold(ctlOutHold)
  );

  lwc_datapath #(.DEF_WIDTH(DEF_WIDTH)) i_datapath (
    .clk(clk), .pwrGoodRstN(pwrGoodRstN), .strb(strb), .wrData(regWrData),
    .activeOut(activeWidthOut), .activeIn(activeWidthIn),
    .addr64En(addr64En), .extCtl(extCtl), .rdData(regRdData)
  );

  // R6
  active_stable_chk: assert property (@(posedge clk) disable iff (!pwrGoodRstN)
    !(linkRst || discDone) |=> ($stable(activeWidthOut) && $stable(activeWidthIn)));

  // R5
  addr64_follow_chk: assert property (@(posedge clk) disable iff (!pwrGoodRstN)
    regWrEn |=> (addr64En == $past(regWrData[A64_BIT])));

  // R4
  max_field_chk: assert property (@(posedge clk) disable iff (!pwrGoodRstN)
    regWrEn |=> (regRdData[22:16] == 7'b0010001));

endmodule

// File: tb/test_link_width_csr.sv
module test_link_width_csr;

  localparam int LONG_CYC = 300;

  logic        clk = 1'b0;
  logic        pwrGoodRstN = 1'b0;
  logic        linkRst = 1'b0;
  logic        discDone = 1'b0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        linkStopN = 1'b1;
  logic        ctlIn = 1'b0;
  logic        bitClkTick = 1'b0;
  logic        ctlOutHold;
  logic [2:0]  activeWidthOut, activeWidthIn;
  logic        addr64En;

  int nChecks = 0;
  int nFails  = 0;

  always #4 clk = ~clk;

  link_width_csr #(.DEF_WIDTH(3'b000), .HOLD_LONG_CYCLES(LONG_CYC), .SHORT_HOLD_TICKS(16))
    i_link_width_csr (
      .clk(clk), .pwrGoodRstN(pwrGoodRstN), .linkRst(linkRst), .discDone(discDone),
      .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData),
      .linkStopN(linkStopN), .ctlIn(ctlIn), .bitClkTick(bitClkTick),
      .ctlOutHold(ctlOutHold), .activeWidthOut(activeWidthOut),
      .activeWidthIn(activeWidthIn), .addr64En(addr64En));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // write word with ones in every reserved and read-only position
  function automatic logic [31:0] mkWr(input logic [2:0] o, input logic [2:0] i,
                                       input logic a64, input logic ext);
    return {1'b1, o, 1'b1, i, 8'hFF, a64, ext, 14'h3FFF};
  endfunction

  function automatic logic [31:0] mkRd(input logic [2:0] o, input logic [2:0] i,
                                       input logic a64, input logic ext);
    return {1'b0, o, 1'b0, i, 8'b0001_0001, a64, ext, 14'h0};
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wrReg(input logic [31:0] d);
    regWrEn = 1'b1; regWrData = d;
    cyc(1);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic pwrReset();
    pwrGoodRstN = 1'b0;
    cyc(2);
    pwrGoodRstN = 1'b1;
    cyc(1);
  endtask

  task automatic testReset();
    check("R1 read", regRdData, 32'h0011_0000);
    check("R1 activeOut", {29'b0, activeWidthOut}, 32'h0);
    check("R1 activeIn", {29'b0, activeWidthIn}, 32'h0);
    check("R1 addr64En", {31'b0, addr64En}, 32'h0);
    check("R1 ctlOutHold", {31'b0, ctlOutHold}, 32'h0);
  endtask

  task automatic testLegalWrites();
    wrReg(mkWr(3'b001, 3'b101, 1'b1, 1'b0));
    check("R2 R4 R5 read 16/4", regRdData, mkRd(3'b001, 3'b101, 1'b1, 1'b0));
    check("R5 addr64En", {31'b0, addr64En}, 32'h1);
    wrReg(mkWr(3'b100, 3'b111, 1'b0, 1'b1));
    check("R2 R5 read 2/nc", regRdData, mkRd(3'b100, 3'b111, 1'b0, 1'b1));
    check("R5 addr64En cleared", {31'b0, addr64En}, 32'h0);
    check("R6 no apply", {26'b0, activeWidthOut, activeWidthIn}, 32'h0);
  endtask

  task automatic testIllegal();
    wrReg(mkWr(3'b000, 3'b001, 1'b0, 1'b0));
    wrReg(mkWr(3'b010, 3'b101, 1'b0, 1'b0));
    check("R3 out rejected, in taken", regRdData, mkRd(3'b000, 3'b101, 1'b0, 1'b0));
    wrReg(mkWr(3'b001, 3'b110, 1'b0, 1'b0));
    check("R3 in rejected, out taken", regRdData, mkRd(3'b001, 3'b101, 1'b0, 1'b0));
    wrReg(mkWr(3'b011, 3'b011, 1'b0, 1'b0));
    check("R3 both rejected", regRdData, mkRd(3'b001, 3'b101, 1'b0, 1'b0));
  endtask

  task automatic testApply();
    // pending is out=001 in=101, active still 000
    cyc(3);
    check("R6 stable while idle", {26'b0, activeWidthOut, activeWidthIn}, 32'h0);
    discDone = 1'b1; cyc(1); discDone = 1'b0;
    check("R6 discDone applies", {26'b0, activeWidthOut, activeWidthIn}, {26'b0, 3'b001, 3'b101});
    wrReg(mkWr(3'b100, 3'b100, 1'b1, 1'b1));
    cyc(2);
    check("R6 deferred", {26'b0, activeWidthOut, activeWidthIn}, {26'b0, 3'b001, 3'b101});
    linkRst = 1'b1; cyc(1); linkRst = 1'b0;
    check("R6 linkRst applies", {26'b0, activeWidthOut, activeWidthIn}, {26'b0, 3'b100, 3'b100});
    check("R8 link reset keeps fields", regRdData, mkRd(3'b100, 3'b100, 1'b1, 1'b1));
  endtask

  task automatic testCollide();
    // write and disconnect-complete at the same edge
    regWrEn = 1'b1; regWrData = mkWr(3'b101, 3'b000, 1'b0, 1'b0); discDone = 1'b1;
    cyc(1);
    regWrEn = 1'b0; discDone = 1'b0;
    check("R7 active old pending", {26'b0, activeWidthOut, activeWidthIn}, {26'b0, 3'b100, 3'b100});
    check("R7 new value pending", regRdData, mkRd(3'b101, 3'b000, 1'b0, 1'b0));
    // write and link reset at the same edge
    regWrEn = 1'b1; regWrData = mkWr(3'b111, 3'b111, 1'b0, 1'b0); linkRst = 1'b1;
    cyc(1);
    regWrEn = 1'b0; linkRst = 1'b0;
    check("R7 linkRst collide", {26'b0, activeWidthOut, activeWidthIn}, {26'b0, 3'b101, 3'b000});
    discDone = 1'b1; cyc(1); discDone = 1'b0;
    check("R7 later apply", {26'b0, activeWidthOut, activeWidthIn}, {26'b0, 3'b111, 3'b111});
    pwrReset();
    check("R8 power-good clears", regRdData, 32'h0011_0000);
    check("R8 power-good active", {26'b0, activeWidthOut, activeWidthIn}, 32'h0);
  endtask

  task automatic stopRelease();
    linkStopN = 1'b0; cyc(2);
    linkStopN = 1'b1; cyc(2);
  endtask

  task automatic testCtlIgnored();
    ctlIn = 1'b1; cyc(4);
    check("R9 ctlIn ignored when idle", {31'b0, ctlOutHold}, 32'h0);
    ctlIn = 1'b0;
    linkStopN = 1'b0; ctlIn = 1'b1; cyc(3);
    check("R9 ctlIn ignored during stop", {31'b0, ctlOutHold}, 32'h0);
    ctlIn = 1'b0; linkStopN = 1'b1; cyc(2);
  endtask

  task automatic testShortHold();
    int ticks;
    wrReg(mkWr(3'b000, 3'b000, 1'b0, 1'b0));
    stopRelease();
    check("R9 no hold before ctlIn", {31'b0, ctlOutHold}, 32'h0);
    ctlIn = 1'b1; cyc(1); ctlIn = 1'b0;
    check("R9 hold rises", {31'b0, ctlOutHold}, 32'h1);
    // bit 14 changed mid-hold must not alter this short hold
    wrReg(mkWr(3'b000, 3'b000, 1'b0, 1'b1));
    ticks = 0;
    for (int k = 0; k < 40 && ctlOutHold; k++) begin
      cyc(2);
      bitClkTick = 1'b1; cyc(1); bitClkTick = 1'b0;
      ticks++;
    end
    check("R10 ticks to release", ticks, 16);
    check("R10 hold low after", {31'b0, ctlOutHold}, 32'h0);
  endtask

  task automatic testLongHold();
    int hi;
    wrReg(mkWr(3'b000, 3'b000, 1'b0, 1'b1));
    stopRelease();
    ctlIn = 1'b1; cyc(1); ctlIn = 1'b0;
    hi = 0;
    for (int k = 0; k < LONG_CYC + 50 && ctlOutHold; k++) begin
      hi++;
      cyc(1);
    end
    check("R11 long hold cycles", hi, LONG_CYC);
  endtask

  task automatic testAbort();
    stopRelease();
    ctlIn = 1'b1; cyc(1); ctlIn = 1'b0;
    cyc(10);
    check("R12 hold running", {31'b0, ctlOutHold}, 32'h1);
    linkStopN = 1'b0; cyc(1);
    check("R12 stop aborts", {31'b0, ctlOutHold}, 32'h0);
    linkStopN = 1'b1; cyc(2);
    ctlIn = 1'b1; cyc(1); ctlIn = 1'b0;
    check("R9 rearmed hold", {31'b0, ctlOutHold}, 32'h1);
    linkRst = 1'b1; cyc(1); linkRst = 1'b0;
    check("R12 link reset aborts", {31'b0, ctlOutHold}, 32'h0);
    ctlIn = 1'b1; cyc(2); ctlIn = 1'b0;
    check("R9 idle after link reset", {31'b0, ctlOutHold}, 32'h0);
  endtask

  initial begin
    cyc(3);
    pwrGoodRstN = 1'b1;
    cyc(1);
    testReset();
    testLegalWrites();
    testIllegal();
    testApply();
    testCollide();
    testCtlIgnored();
    testShortHold();
    testLongHold();
    testAbort();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule